// File: doc/BRIEF.md
# Debug Signal Stripe Serializer

This block turns a wide bundle of internal debug signals into a column pattern on a raster display, with no frame buffer and no character generator. Each time the horizontal sync goes high, the block captures the current debug word. During the visible part of the following line, it sends that word out one bit per pixel clock. A set bit shows as a bright dot and a clear bit shows as a dim dot, so each signal forms a vertical stripe down the screen.

To make it easier to see which column belongs to which signal, the bright and dim colours switch between two palettes after every fixed group of bits. After the last bit of the word, any remaining visible pixels take a background colour. Outside the visible window the output is black. The block sits between an existing timing generator, which supplies sync and display-enable, and the pixel output path.

Top module: `sigstripe_raster`

## Requirements
- R1: After reset the pixel output is 0 (black), and no word is held: visible pixels before the first load show the background colour 12'h006.
- R2: A word is captured only on a rising edge of `hsync` (a low-to-high change between two clock edges). Holding `hsync` high does not capture again, even if `dbg_word` changes.
- R3: Bits leave most significant bit first, one per clock cycle in which `de` is high. Cycles with `de` low do not consume a bit.
- R4: In the first palette a set bit gives 12'hFFF and a clear bit gives 12'h222.
- R5: The palette alternates after every GROUP bits sent (default 8), starting with the first palette after each capture. The second palette gives 12'hFC0 for a set bit and 12'h430 for a clear bit.
- R6: After all WORD_W bits of a word have been sent, every further visible pixel is the background colour 12'h006 until the next capture.
- R7: When `de` is low, the pixel output is 12'h000.
- R8: The pixel for the inputs sampled at one rising clock edge appears on `pixel` right after that edge. This means one register of latency from `de` to `pixel`.
- R9: A capture restarts the bit position, group count and palette, even when the previous line did not send all of its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | input | 1 | Horizontal sync, active high; its rising edge captures the word |
| de | input | 1 | Display enable, high during visible pixels |
| dbg_word | input | WORD_W | Parallel debug signals to show |
| pixel | output | 12 | RGB 4:4:4 colour of the current dot |

## Verification
The assertions assume that a rising edge of `hsync` never falls in a cycle with `de` high, which is how sync and visible video are laid out on any raster line. The bench keeps to this rule: every line it drives puts blank cycles on both sides of the sync pulse. It then varies the debug word, the number of visible pixels, the spacing of gaps in `de`, and how long `hsync` stays high. This covers lines shorter and longer than the word, a sync held high while the word changes, and isolated single-pixel enables.

// File: rtl/sigstripe_pkg.sv
// Shared colour type and fixed colour values for the stripe serializer.
package sigstripe_pkg;
    typedef logic [11:0] rgb_t;

    localparam rgb_t RGB_BLACK = 12'h000;
endpackage

// File: rtl/sigstripe_edge.sv
// Rising-edge detector for the line sync.
// Assumes sync_in is synchronous to clk. Produces a one-cycle pulse in the
// cycle where sync_in is high and was low at the previous clock edge.
module sigstripe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic rise
);
    logic sync_q;

    // Remember the sync level from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_in;
    end

    // A capture pulse is a high level following a low one.
    always_comb rise = sync_in && !sync_q;

    // R2: a capture pulse can never last two cycles in a row.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sigstripe_shifter.sv
// Parallel-load, MSB-first shift register with a count of bits still to send.
// Assumes load and advance are never high together in a correct system;
// if they are, load wins and no bit is consumed.
module sigstripe_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [WORD_W-1:0] word_in,
    output logic              bit_out,
    output logic              drained,
    output logic              stepped
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  remain;

    // A bit is consumed only on a visible cycle with bits left and no capture.
    always_comb stepped = advance && !load && (remain != '0);
    always_comb drained = (remain == '0);
    always_comb bit_out = shreg[WORD_W-1];

    // Capture the word, or move the next bit into the top position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            remain <= '0;
        end else if (load) begin
            shreg  <= word_in;
            remain <= CNT_W'(WORD_W);
        end else if (stepped) begin
            shreg  <= {shreg[WORD_W-2:0], 1'b0};
            remain <= remain - 1'b1;
        end
    end

    // R2: a capture always leaves the full word pending.
    a_r2_full_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (remain == CNT_W'(WORD_W)));
    // R3: without capture or enable the register and count hold.
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> ($stable(shreg) && $stable(remain)));
    // R6: once empty, the register stays empty until the next capture.
    a_r6_stays_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (drained && !load) |=> drained);
endmodule

// File: rtl/sigstripe_palette.sv
// Group counter and two-palette colour selection.
// Assumes step pulses once per bit sent and never together with load.
// The colour output is combinational from the current phase and bit.
module sigstripe_palette
    import sigstripe_pkg::*;
#(
    parameter int   GROUP = 8,
    parameter rgb_t A_LIT = 12'hFFF,
    parameter rgb_t A_DRK = 12'h222,
    parameter rgb_t B_LIT = 12'hFC0,
    parameter rgb_t B_DRK = 12'h430
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    input  logic bit_in,
    output rgb_t colour
);
    localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam logic [GW-1:0] LAST = GW'(GROUP - 1);

    logic [GW-1:0] grp;
    logic          phase;

    // Count bits within the group and flip palette at each group end.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            grp   <= '0;
            phase <= 1'b0;
        end else if (step) begin
            if (grp == LAST) begin
                grp   <= '0;
                phase <= !phase;
            end else begin
                grp <= grp + 1'b1;
            end
        end
    end

    // Pick the bright or dim shade of the active palette.
    always_comb begin
        if (phase) colour = bit_in ? B_LIT : B_DRK;
        else       colour = bit_in ? A_LIT : A_DRK;
    end

    // R9: every capture restarts the group and the palette.
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (grp == '0 && !phase));
    // R5: the last bit of a group flips the palette.
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (step && grp == LAST) |=> (phase != $past(phase)));
    // R5: within a group the palette holds.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(step && grp == LAST)) |=> $stable(phase));
endmodule

// File: rtl/sigstripe_raster.sv
// Top of the debug stripe serializer.
// Captures dbg_word on each rising hsync and sends it MSB first, one bit per
// visible pixel, as bright or dim dots in alternating palettes. Assumes the
// hsync rising edge never coincides with de high.
module sigstripe_raster
    import sigstripe_pkg::*;
#(
    parameter int   WORD_W = 32,
    parameter int   GROUP  = 8,
    parameter rgb_t A_LIT  = 12'hFFF,
    parameter rgb_t A_DRK  = 12'h222,
    parameter rgb_t B_LIT  = 12'hFC0,
    parameter rgb_t B_DRK  = 12'h430,
    parameter rgb_t BG     = 12'h006
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              de,
    input  logic [WORD_W-1:0] dbg_word,
    output logic [11:0]       pixel
);
    logic load;
    logic cur_bit;
    logic drained;
    logic stepped;
    rgb_t bit_colour;
    rgb_t pix_q;
    logic primed;

    sigstripe_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (hsync),
        .rise    (load)
    );

    sigstripe_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (de),
        .word_in (dbg_word),
        .bit_out (cur_bit),
        .drained (drained),
        .stepped (stepped)
    );

    sigstripe_palette #(
        .GROUP (GROUP),
        .A_LIT (A_LIT),
        .A_DRK (A_DRK),
        .B_LIT (B_LIT),
        .B_DRK (B_DRK)
    ) u_pal (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (stepped),
        .bit_in (cur_bit),
        .colour (bit_colour)
    );

    // Register the dot colour: black when blanked, background once drained.
    always_ff @(posedge clk) begin
        if (!rst_n)       pix_q <= RGB_BLACK;
        else if (!de)     pix_q <= RGB_BLACK;
        else if (drained) pix_q <= BG;
        else              pix_q <= bit_colour;
    end

    // Mark that one edge has passed since reset, for history-based checks.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    assign pixel = pix_q;

    // R7: a blanked input cycle gives a black dot.
    a_r7_black: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(de)) |-> (pixel == RGB_BLACK));
    // R6: a visible cycle after the word is drained gives the background.
    a_r6_background: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(de) && $past(drained)) |-> (pixel == BG));
    // R8: a visible cycle with bits left shows the selected shade next cycle.
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(de) && !$past(drained)) |-> (pixel == $past(bit_colour)));
    // R3: the assumed layout, no capture while visible.
    a_r3_no_load_in_video: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && de));
endmodule

// File: tb/sigstripe_raster_bench.sv
// Scoreboard bench: the driver pushes the expected dot for each driven cycle,
// the monitor pops and compares one cycle later.
module sigstripe_raster_bench;
    localparam int W = 32;
    localparam int G = 8;

    typedef struct {
        logic [11:0] px;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hsync = 1'b0;
    logic          de = 1'b0;
    logic [W-1:0]  dbg_word = '0;
    logic [11:0]   pixel;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    // Bench model state, written from the requirements.
    logic [W-1:0] m_sh = '0;
    int           m_rem = 0;
    int           m_grp = 0;
    bit           m_ph = 1'b0;
    bit           prev_hs = 1'b0;

    sigstripe_raster u_sigstripe_raster (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync    (hsync),
        .de       (de),
        .dbg_word (dbg_word),
        .pixel    (pixel)
    );

    always #4 clk = ~clk;

    function automatic logic [11:0] shade(input bit b, input bit ph);
        if (ph) return b ? 12'hFC0 : 12'h430;
        return b ? 12'hFFF : 12'h222;
    endfunction

    // Drive one cycle and push what must appear after the next edge.
    task automatic drive(input bit hs, input bit en, input logic [W-1:0] w, input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        hsync = hs; de = en; dbg_word = w;
        if (!en)             begin e.px = 12'h000; e.tag = "R7"; end
        else if (m_rem == 0) begin e.px = 12'h006; e.tag = (tag == "R1") ? "R1" : "R6"; end
        else                 begin e.px = shade(m_sh[W-1], m_ph); e.tag = tag; end
        if (hs && !prev_hs) begin
            m_sh = w; m_rem = W; m_grp = 0; m_ph = 1'b0;
        end else if (en && m_rem > 0) begin
            m_sh = m_sh << 1;
            m_rem--;
            if (m_grp == G - 1) begin m_grp = 0; m_ph = !m_ph; end
            else m_grp++;
        end
        prev_hs = hs;
        q.push_back(e);
    endtask

    // One raster line: sync, porch, visible run with optional gaps.
    task automatic line(input logic [W-1:0] w, input int npx, input int gap, input string tag);
        drive(0, 0, w, tag);
        drive(0, 0, w, tag);
        for (int i = 0; i < 3; i++) drive(1, 0, w, tag);
        drive(0, 0, ~w, tag);
        drive(0, 0, ~w, tag);
        for (int i = 0; i < npx; i++) begin
            drive(0, 1, ~w, tag);
            if (gap != 0 && (i % gap) == gap - 1) drive(0, 0, ~w, tag);
        end
        drive(0, 0, ~w, tag);
    endtask

    // Monitor: compare the dot produced for the previous driven cycle.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (pixel !== e.px) begin
                bad++;
                $display("FAIL %s: pixel=%h expected=%h", e.tag, pixel, e.px);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (pixel !== 12'h000) begin
            bad++;
            $display("FAIL R1: pixel=%h expected=%h", pixel, 12'h000);
        end
        #1 rst_n = 1'b1;

        // R1: blank then visible with nothing captured.
        for (int i = 0; i < 3; i++) drive(0, 0, '0, "R1");
        for (int i = 0; i < 4; i++) drive(0, 1, '0, "R1");
        drive(0, 0, '0, "R1");

        // R4, R6: mixed pattern, line longer than the word.
        line(32'hA5F0_0F5A, 40, 0, "R4");
        // R5: all ones shows both bright shades.
        line(32'hFFFF_FFFF, 36, 0, "R5");
        // R5: all zeros shows both dim shades.
        line(32'h0000_0000, 34, 0, "R5");
        // R3: gaps in enable do not consume bits.
        line(32'h8000_0001, 34, 3, "R3");

        // R2: sync held high while the word changes: only the first is used.
        drive(0, 0, 32'h1234_5678, "R2");
        drive(1, 0, 32'hF0F0_F0F0, "R2");
        for (int i = 0; i < 4; i++) drive(1, 0, 32'h0F0F_0F0F, "R2");
        drive(0, 0, 32'h0F0F_0F0F, "R2");
        for (int i = 0; i < 33; i++) drive(0, 1, 32'h0000_0000, "R2");
        drive(0, 0, '0, "R2");

        // R9: short line then new word restarts position and palette.
        line(32'hC3C3_C3C3, 11, 0, "R9");
        line(32'h3C00_FF81, 20, 0, "R9");

        // R8: isolated single-pixel enables.
        drive(0, 0, 32'h9669_5AA5, "R8");
        drive(1, 0, 32'h9669_5AA5, "R8");
        drive(0, 0, 32'h9669_5AA5, "R8");
        for (int i = 0; i < 20; i++) begin
            drive(0, 1, '0, "R8");
            drive(0, 0, '0, "R8");
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule